// File: doc/BRIEF.md
# Montgomery Modular Exponentiation Unit

This block raises a wide base to a wide power modulo an odd modulus, Y = X^E mod M. It needs no divider. Every modular product is a radix-2 Montgomery product with R = 2^W, where W is the operand width. The caller supplies the constant R^2 mod M together with X, E and M. A single multiplier sits inside the unit and is shared by every step. It retires one bit of its first operand per clock.

The controller runs the job in three phases. First it moves the base into the Montgomery domain and forms the Montgomery image of one. It then walks the exponent from its leading set bit down to bit zero. Each bit costs one squaring, and a set bit adds one multiplication by the converted base. Last, a product with the constant 1 brings the result back into the normal domain.

A request is a single-cycle start strobe. All inputs are captured on that strobe. The result appears on a one-cycle done pulse and then holds. The width targets 1024 bits; small widths keep the verification short. Public-key encryption, decryption, signing and verification all map onto this one operation.

Top module: `modexp_mont`

## Requirements
- R1: For an odd modulus M, a base X < M, any exponent E below 2^W and r2_i = 2^(2W) mod M, the value on result_o at the done pulse equals X^E mod M.
- R2: An exponent of zero gives result_o = 1 mod M.
- R3: The result presented with done_o, and every internal Montgomery product, is strictly less than M.
- R4: done_o is high for exactly one clock per accepted request. result_o changes only in the cycle in which done_o rises and otherwise holds. After reset, done_o and result_o are 0.
- R5: base_i, exp_i, mod_i and r2_i are sampled only in the cycle in which start_i is accepted. Changing them afterwards does not change the pending result.
- R6: A start_i pulse that arrives while a request is in progress is ignored. It produces no extra done pulse and does not alter the pending result.
- R7: Exponent corners: E = 1 returns X, and E = 2^W - 1 (every bit set) returns X^E mod M.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request strobe, accepted only when idle |
| base_i | input | W | Base X, required below the modulus |
| exp_i | input | W | Exponent E |
| mod_i | input | W | Odd modulus M |
| r2_i | input | W | Constant 2^(2W) mod M |
| result_o | output | W | Result X^E mod M, held between requests |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The assertions check several properties on every cycle. Each finished Montgomery product and each delivered result must stay below the captured modulus. done_o must never stay high for two cycles. result_o must hold whenever done_o is low. A start strobe that arrives during a run must leave the captured modulus untouched. Only the bench scenarios can show that the arithmetic is right: they compare the output against a behavioural power-mod over random odd moduli and over exponents of zero, one and all ones. Only the bench can also show that late input changes and start strobes during a run leave the answer and the pulse count unchanged.

// File: rtl/modexp_mont.sv
module modexp_mont #(
  parameter int W = 1024
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic [W-1:0] base_i,
  input  logic [W-1:0] exp_i,
  input  logic [W-1:0] mod_i,
  input  logic [W-1:0] r2_i,
  output logic [W-1:0] result_o,
  output logic         done_o
);
  localparam int CW = $clog2(W + 1);
  localparam logic [W-1:0] ONE = W'(1);

  typedef enum logic [2:0] {S_IDLE, S_TOX, S_ONE, S_SCAN, S_SQR, S_MUL, S_OUT} st_t;
  st_t state, nstate;

  logic [W-1:0]  m_q, r2_q, xm, acc, e_sh;
  logic [CW-1:0] bcnt;
  logic          seen;

  logic [W-1:0]  ma, mb;
  logic [W+1:0]  macc;
  logic [CW-1:0] mcnt;
  logic          mbusy, mfin;

  logic [W+1:0]  t1, t2, diff, mnext;
  logic [W-1:0]  mres;

  logic          ld, adv, acc_ld, xm_ld, y_ld, seen_set;
  logic [W-1:0]  la, lb;
  logic          busy;

  assign t1    = macc + (ma[0] ? {2'b00, mb} : '0);
  assign t2    = t1 + (t1[0] ? {2'b00, m_q} : '0);
  assign mnext = {1'b0, t2[W+1:1]};
  assign diff  = macc - {2'b00, m_q};
  assign mres  = (macc >= {2'b00, m_q}) ? diff[W-1:0] : macc[W-1:0];
  assign busy  = (state != S_IDLE);

  always_comb begin
    nstate   = state;
    ld       = 1'b0;
    la       = '0;
    lb       = '0;
    adv      = 1'b0;
    acc_ld   = 1'b0;
    xm_ld    = 1'b0;
    y_ld     = 1'b0;
    seen_set = 1'b0;
    case (state)
      S_IDLE: if (start_i) begin
        ld = 1'b1; la = base_i; lb = r2_i; nstate = S_TOX;
      end
      S_TOX: if (mfin) begin
        xm_ld = 1'b1; ld = 1'b1; la = r2_q; lb = ONE; nstate = S_ONE;
      end
      S_ONE: if (mfin) begin
        acc_ld = 1'b1; nstate = S_SCAN;
      end
      S_SCAN: begin
        if (bcnt == '0) begin
          ld = 1'b1; la = acc; lb = ONE; nstate = S_OUT;
        end else if (seen || e_sh[W-1]) begin
          seen_set = 1'b1; ld = 1'b1; la = acc; lb = acc; nstate = S_SQR;
        end else begin
          adv = 1'b1;
        end
      end
      S_SQR: if (mfin) begin
        acc_ld = 1'b1;
        if (e_sh[W-1]) begin
          ld = 1'b1; la = mres; lb = xm; nstate = S_MUL;
        end else begin
          adv = 1'b1; nstate = S_SCAN;
        end
      end
      S_MUL: if (mfin) begin
        acc_ld = 1'b1; adv = 1'b1; nstate = S_SCAN;
      end
      S_OUT: if (mfin) begin
        y_ld = 1'b1; nstate = S_IDLE;
      end
      default: nstate = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ma    <= '0;
      mb    <= '0;
      macc  <= '0;
      mcnt  <= '0;
      mbusy <= 1'b0;
      mfin  <= 1'b0;
    end else if (ld) begin
      ma    <= la;
      mb    <= lb;
      macc  <= '0;
      mcnt  <= '0;
      mbusy <= 1'b1;
      mfin  <= 1'b0;
    end else if (mbusy) begin
      ma    <= ma >> 1;
      macc  <= mnext;
      mcnt  <= mcnt + 1'b1;
      if (mcnt == CW'(W - 1)) begin
        mbusy <= 1'b0;
        mfin  <= 1'b1;
      end
    end else begin
      mfin  <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      m_q      <= '0;
      r2_q     <= '0;
      xm       <= '0;
      acc      <= '0;
      e_sh     <= '0;
      bcnt     <= '0;
      seen     <= 1'b0;
      result_o <= '0;
      done_o   <= 1'b0;
    end else begin
      state  <= nstate;
      done_o <= y_ld;
      if (state == S_IDLE && start_i) begin
        m_q  <= mod_i;
        r2_q <= r2_i;
        e_sh <= exp_i;
        seen <= 1'b0;
      end
      if (state == S_ONE && mfin) bcnt <= CW'(W);
      if (xm_ld)    xm <= mres;
      if (acc_ld)   acc <= mres;
      if (seen_set) seen <= 1'b1;
      if (adv) begin
        e_sh <= e_sh << 1;
        bcnt <= bcnt - 1'b1;
      end
      if (y_ld) result_o <= mres;
    end
  end
endmodule

// File: rtl/modexp_mont_chk.sv
module modexp_mont_chk #(
  parameter int W = 1024
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start_i,
  input logic         done_o,
  input logic [W-1:0] result_o,
  input logic [W-1:0] m_q,
  input logic         busy,
  input logic         mfin,
  input logic [W-1:0] mres
);
  a_r4_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r4_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(result_o));

  a_r3_result_lt_mod: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (result_o < m_q));

  a_r3_product_lt_mod: assert property (@(posedge clk) disable iff (!rst_n)
    mfin |-> (mres < m_q));

  a_r6_busy_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start_i) |=> $stable(m_q));
endmodule

bind modexp_mont modexp_mont_chk #(.W(W)) chk_i (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .done_o(done_o),
  .result_o(result_o), .m_q(m_q), .busy(busy), .mfin(mfin), .mres(mres)
);

// File: tb/modexp_mont_tb.sv
module modexp_mont_tb_top;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start_i = 1'b0;
  logic [W-1:0] base_i = '0, exp_i = '0, mod_i = '0, r2_i = '0;
  logic [W-1:0] result_o;
  logic         done_o;

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  modexp_mont #(.W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .base_i(base_i),
    .exp_i(exp_i), .mod_i(mod_i), .r2_i(r2_i), .result_o(result_o), .done_o(done_o)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000 && !finished) begin
      finished = 1;
      n_err++;
      $display("FAIL watchdog: act=%0d cycles exp=<190000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", n_chk + 1, n_err);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: act=%0h exp=%0h", req, act, expv);
    end
  endtask

  function automatic logic [31:0] ref_pow(input logic [31:0] x, input logic [31:0] e, input logic [31:0] m);
    logic [63:0] r = 64'd1 % m;
    logic [63:0] b = x % m;
    for (int i = 31; i >= 0; i--) begin
      r = (r * r) % m;
      if (e[i]) r = (r * b) % m;
    end
    return r[31:0];
  endfunction

  function automatic logic [31:0] calc_r2(input logic [31:0] m);
    logic [63:0] r = (64'd1 << 32) % m;
    return 32'((r * r) % m);
  endfunction

  task automatic launch(input logic [31:0] x, input logic [31:0] e, input logic [31:0] m);
    @(negedge clk);
    base_i = x; exp_i = e; mod_i = m; r2_i = calc_r2(m);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_done(output logic [31:0] y, output bit ok);
    ok = 0;
    for (int i = 0; i < 5000; i++) begin
      if (done_o) begin ok = 1; break; end
      @(negedge clk);
    end
    y = result_o;
  endtask

  task automatic run_op(input logic [31:0] x, input logic [31:0] e, input logic [31:0] m,
                        input string req);
    logic [31:0] y, ev;
    bit ok;
    ev = ref_pow(x, e, m);
    launch(x, e, m);
    wait_done(y, ok);
    check(ok, {req, " done seen"}, 64'(ok), 64'd1);
    check(y == ev, req, 64'(y), 64'(ev));
    check(y < m, "R3 result below modulus", 64'(y), 64'(m));
    @(negedge clk);
    check(!done_o, "R4 done one cycle", 64'(done_o), 64'd0);
  endtask

  task automatic t_reset();
    check(done_o == 1'b0, "R4 reset done", 64'(done_o), 64'd0);
    check(result_o == '0, "R4 reset result", 64'(result_o), 64'd0);
  endtask

  task automatic t_random();
    for (int k = 0; k < 20; k++) begin
      logic [31:0] m = $urandom() | 32'h8000_0001;
      logic [31:0] x = $urandom() % m;
      logic [31:0] e = $urandom();
      run_op(x, e, m, "R1 random power");
    end
    run_op(32'd2, 32'd10, 32'd1001, "R1 small modulus");
    run_op(32'hFFFF_FFFD, 32'd3, 32'hFFFF_FFFF, "R1 max modulus");
  endtask

  task automatic t_zero_exp();
    run_op(32'h1234_5678, 32'd0, 32'hC000_0001, "R2 zero exponent");
    run_op(32'd0, 32'd0, 32'd7, "R2 zero exponent zero base");
  endtask

  task automatic t_exp_corners();
    run_op(32'h0ABC_DEF1, 32'd1, 32'hF123_4567, "R7 exponent one");
    run_op(32'h5555_AAAA, 32'hFFFF_FFFF, 32'hE000_0003, "R7 exponent all ones");
    run_op(32'h0000_0003, 32'h8000_0000, 32'hB000_0005, "R7 exponent top bit only");
  endtask

  task automatic t_late_inputs();
    logic [31:0] y, ev, held;
    bit ok;
    ev = ref_pow(32'h0101_0101, 32'h00F0_0F0F, 32'hD555_5557);
    launch(32'h0101_0101, 32'h00F0_0F0F, 32'hD555_5557);
    base_i = 32'h7777_7777; exp_i = 32'h1; mod_i = 32'h0000_0011; r2_i = 32'h5;
    wait_done(y, ok);
    check(ok && y == ev, "R5 inputs sampled at start", 64'(y), 64'(ev));
    held = y;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      base_i = $urandom();
    end
    check(result_o == held, "R4 result held after done", 64'(result_o), 64'(held));
  endtask

  task automatic t_busy_start();
    logic [31:0] y, ev;
    bit ok;
    int extra = 0;
    ev = ref_pow(32'h2222_3333, 32'hABCD_0001, 32'hF0F0_F0F1);
    launch(32'h2222_3333, 32'hABCD_0001, 32'hF0F0_F0F1);
    repeat (60) @(negedge clk);
    base_i = 32'h5; exp_i = 32'h2; mod_i = 32'h0000_000B; r2_i = calc_r2(32'h0000_000B);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    wait_done(y, ok);
    check(ok && y == ev, "R6 start while busy ignored", 64'(y), 64'(ev));
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (done_o) extra++;
    end
    check(extra == 0, "R6 no extra done pulse", 64'(extra), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_random();
    t_zero_exp();
    t_exp_corners();
    t_late_inputs();
    t_busy_start();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule